// File: doc/BRIEF.md
# Frame-Indexed Memory Move Sequencer

This block carries out three memory-to-memory byte moves. In each one the source byte sits at a 14-bit frame pointer plus a small offset. The instructions arrive as a stream of 16-bit words. The sequencer reads the first word, gathers the source offset and the destination from the words that follow, then reads one byte from data memory and writes it back to memory once.

- **Short-absolute move:** sends the byte to a 12-bit absolute address.
- **Long-absolute move:** spans three words and sends the byte to a full 14-bit address.
- **Frame-to-frame move:** sends the byte to the frame pointer plus a second offset.

A small set of registers is treated specially, and their addresses are set by parameters:

- **Indirect-access registers:** a read from one of them supplies 00h. A frame-to-frame move that lands on one of them does nothing.
- **Protected registers:** these may never be written. A move aimed at one of them is dropped and raises an error pulse.

Instruction words enter through a valid/ready stream. A word is consumed on a clock edge where `word_valid` and `word_ready` are both high. The producer must hold `word_data` steady while `word_valid` is high and not yet accepted. The sequencer accepts words while it is collecting an instruction. It deasserts `word_ready` during the two cycles in which it touches memory. A producer may leave gaps of any length between words. `frame_ptr` must stay constant from the first word of an instruction until its `done`. The data memory has a synchronous read: `mem_rdata` carries the byte addressed in the cycle after `mem_rd_en`.

Top module: `fims_move_seq`

## Requirements
- R1: After reset `word_ready` is 1, and `mem_rd_en`, `mem_wr_en`, `done` and `err` are 0.
- R2: A first word whose bits [15:7] are 111010110 starts a short-absolute move, with the source offset in bits [6:0]. Bits [11:0] of the next word give the destination, zero-extended to 14 bits.
- R3: A first word whose bits [15:7] are 111010111 starts a frame-to-frame move, with the source offset in bits [6:0]. Bits [6:0] of the next word are the destination offset, so the destination is frame pointer plus that offset. Bits [11:7] of that word are ignored.
- R4: A first word equal to 0062h starts a long-absolute move. In the second word, bits [8:2] are the source offset, bits [1:0] are destination bits [13:12], and bits [11:9] are ignored. Bits [11:0] of the third word are destination bits [11:0].
- R5: The source address is the frame pointer plus the zero-extended 7-bit offset, taken modulo 2^14.
- R6: When the source address is an indirect-access register, the byte written is 00h, whatever the memory returns.
- R7: In a frame-to-frame move whose destination is an indirect-access register, no write occurs and `err` stays 0. `done` still pulses.
- R8: When the destination is a protected register, no write occurs, and `err` pulses together with `done`.
- R9: A second or third word whose bits [15:12] are not 1111 is consumed and aborts the instruction. No memory access and no `done` follow. `err` is 1 for the one cycle after that word is accepted, and the sequencer then accepts a new first word.
- R10: A word is consumed only on a cycle where `word_valid` and `word_ready` are both high. `word_ready` is 0 in the read cycle and in the write cycle, and the sequencer waits indefinitely for each follow-on word.
- R11: `mem_rd_en` is 1 in the cycle right after the last word is accepted, with `mem_addr` holding the source address. In the next cycle `done` pulses for one cycle, and any write happens with `mem_addr` holding the destination.
- R12: A word in the first-word position that matches none of the three openings is consumed with no memory access, no `done` and no `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_ptr | input | 14 | Frame pointer used for indexed addresses |
| word_data | input | 16 | Instruction word |
| word_valid | input | 1 | `word_data` holds a word |
| word_ready | output | 1 | Sequencer accepts a word this cycle |
| mem_addr | output | 14 | Data-memory address (source on read, destination on write) |
| mem_rd_en | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | One-cycle pulse when a move finishes |
| err | output | 1 | One-cycle pulse on a protected destination or an aborted instruction |

## Verification
The bench aims at the following corner cases, and at the fault each one would expose:

- **Source wrap:** the frame pointer sits near 3FFFh. A design that carried into a fifteenth bit, or sign-extended the offset, would read the wrong byte.
- **Long-absolute field split:** the source offset and the top destination bits share the second word. Misplacing either field sends the byte to the wrong address.
- **Indirect-access registers:** one case reads from such a register as source, and another targets one as a frame-to-frame destination. A faulty design would copy the raw memory byte, or write where it should stay silent.
- **Protected destinations and bad follow-on words:** these must suppress the write and raise the error pulse.
- **Stream gaps and back-to-back words:** the stream has gaps between words and back-to-back words while the sequencer is busy. A design that ignored `word_ready` would drop or duplicate words.
- **Non-instruction word:** one word matches no opening and must be swallowed without any effect.

// File: rtl/fims_pkg.sv
package fims_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 8;
  localparam int WORD_W = 16;
  localparam int OFF_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W2,
    ST_W3,
    ST_RD,
    ST_WR
  } fims_state_t;

  typedef enum logic [1:0] {
    OP_ABS12,
    OP_IDX,
    OP_ABS14
  } fims_op_t;
endpackage

// File: rtl/fims_decode.sv
module fims_decode
  import fims_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              is_abs12,
  output logic              is_idx,
  output logic              is_abs14,
  output logic [OFF_W-1:0]  offset
);
  // Opening words: short-absolute and frame-to-frame share the upper byte.
  assign is_abs12 = (word[15:7] == 9'b1110_1011_0);
  assign is_idx   = (word[15:7] == 9'b1110_1011_1);
  assign is_abs14 = (word == 16'h0062);
  assign offset   = word[OFF_W-1:0];
endmodule

// File: rtl/fims_addr_match.sv
module fims_addr_match
  import fims_pkg::*;
#(
  parameter int                      N    = 1,
  parameter logic [N*ADDR_W-1:0]     LIST = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [N-1:0] hits;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = (addr == LIST[g*ADDR_W +: ADDR_W]);
  end

  assign hit = |hits;
endmodule

// File: rtl/fims_frame_add.sv
module fims_frame_add
  import fims_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] sum
);
  // Zero-extended offset, result wraps inside the address space.
  assign sum = base + {{(ADDR_W-OFF_W){1'b0}}, off};
endmodule

// File: rtl/fims_move_seq.sv
module fims_move_seq
  import fims_pkg::*;
#(
  parameter int                          N_IND      = 3,
  parameter logic [N_IND*ADDR_W-1:0]     IND_LIST   = {14'h3FEF, 14'h3FE7, 14'h3FDF},
  parameter int                          N_PROT     = 4,
  parameter logic [N_PROT*ADDR_W-1:0]    PROT_LIST  = {14'h3FF9, 14'h3FFD, 14'h3FFE, 14'h3FFF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] frame_ptr,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic              err
);
  localparam int HI_W = ADDR_W - 12;

  fims_state_t       state_q, state_d;
  fims_op_t          op_q, op_d;
  logic [OFF_W-1:0]  soff_q, soff_d;
  logic [ADDR_W-1:0] dfield_q, dfield_d;
  logic              abort_q, abort_d;

  logic              accept, tail_ok;
  logic              dec_abs12, dec_idx, dec_abs14;
  logic [OFF_W-1:0]  dec_off;
  logic [ADDR_W-1:0] src_addr, dst_idx, dst_addr;
  logic              src_ind, dst_ind, dst_prot, suppress;

  fims_decode u_dec (
    .word     (word_data),
    .is_abs12 (dec_abs12),
    .is_idx   (dec_idx),
    .is_abs14 (dec_abs14),
    .offset   (dec_off)
  );

  fims_frame_add u_src_add (
    .base (frame_ptr),
    .off  (soff_q),
    .sum  (src_addr)
  );

  fims_frame_add u_dst_add (
    .base (frame_ptr),
    .off  (dfield_q[OFF_W-1:0]),
    .sum  (dst_idx)
  );

  assign dst_addr = (op_q == OP_IDX) ? dst_idx : dfield_q;

  fims_addr_match #(.N(N_IND), .LIST(IND_LIST)) u_src_ind (
    .addr (src_addr),
    .hit  (src_ind)
  );

  fims_addr_match #(.N(N_IND), .LIST(IND_LIST)) u_dst_ind (
    .addr (dst_addr),
    .hit  (dst_ind)
  );

  fims_addr_match #(.N(N_PROT), .LIST(PROT_LIST)) u_dst_prot (
    .addr (dst_addr),
    .hit  (dst_prot)
  );

  // Stream side
  assign word_ready = (state_q == ST_IDLE) || (state_q == ST_W2) || (state_q == ST_W3);
  assign accept     = word_valid && word_ready;
  assign tail_ok    = (word_data[15:12] == 4'hF);

  // Memory side
  assign suppress  = dst_prot || ((op_q == OP_IDX) && dst_ind);
  assign mem_rd_en = (state_q == ST_RD);
  assign mem_wr_en = (state_q == ST_WR) && !suppress;
  assign mem_addr  = (state_q == ST_WR) ? dst_addr : src_addr;
  assign mem_wdata = src_ind ? '0 : mem_rdata;
  assign done      = (state_q == ST_WR);
  assign err       = ((state_q == ST_WR) && dst_prot) || abort_q;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    soff_d   = soff_q;
    dfield_d = dfield_q;
    abort_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dec_abs12) begin
            op_d    = OP_ABS12;
            soff_d  = dec_off;
            state_d = ST_W2;
          end else if (dec_idx) begin
            op_d    = OP_IDX;
            soff_d  = dec_off;
            state_d = ST_W2;
          end else if (dec_abs14) begin
            op_d    = OP_ABS14;
            state_d = ST_W2;
          end
        end
      end
      ST_W2: begin
        if (accept) begin
          if (!tail_ok) begin
            abort_d = 1'b1;
            state_d = ST_IDLE;
          end else begin
            unique case (op_q)
              OP_ABS12: begin
                dfield_d = {{HI_W{1'b0}}, word_data[11:0]};
                state_d  = ST_RD;
              end
              OP_IDX: begin
                dfield_d = {{(ADDR_W-OFF_W){1'b0}}, word_data[OFF_W-1:0]};
                state_d  = ST_RD;
              end
              default: begin
                soff_d   = word_data[OFF_W+1:2];
                dfield_d = {word_data[HI_W-1:0], 12'h000};
                state_d  = ST_W3;
              end
            endcase
          end
        end
      end
      ST_W3: begin
        if (accept) begin
          if (!tail_ok) begin
            abort_d = 1'b1;
            state_d = ST_IDLE;
          end else begin
            dfield_d = {dfield_q[ADDR_W-1:12], word_data[11:0]};
            state_d  = ST_RD;
          end
        end
      end
      ST_RD:   state_d = ST_WR;
      ST_WR:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_ABS12;
      soff_q   <= '0;
      dfield_q <= '0;
      abort_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      soff_q   <= soff_d;
      dfield_q <= dfield_d;
      abort_q  <= abort_d;
    end
  end
endmodule

// File: rtl/fims_sva.sv
module fims_sva
  import fims_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              word_ready,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              done,
  input logic              err
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R11
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en)); // R11
  AST_DONE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd_en)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || done) |-> !word_ready); // R10
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !done) |-> (!mem_rd_en && !mem_wr_en)); // R9
  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (err && done) |-> !mem_wr_en); // R8
endmodule

bind fims_move_seq fims_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_ready (word_ready),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .done       (done),
  .err        (err)
);

// File: tb/fims_move_seq_tb.sv
module fims_move_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] frame_ptr = '0;
  logic [15:0] word_data = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [13:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata = '0;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic        done;
  logic        err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  fims_move_seq u_dut (
    .clk(clk), .rst_n(rst_n), .frame_ptr(frame_ptr),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .done(done), .err(err)
  );

  // Behavioural data memory: written bytes kept sparsely, the rest computed.
  logic [7:0] wmem [int];

  function automatic logic [7:0] rd_mem(int a);
    if (wmem.exists(a)) return wmem[a];
    return 8'((a * 13 + 7) & 255);
  endfunction

  function automatic bit is_ind(int a);
    return a == 'h3FEF || a == 'h3FE7 || a == 'h3FDF;
  endfunction

  function automatic bit is_prot(int a);
    return a == 'h3FF9 || a == 'h3FFD || a == 'h3FFE || a == 'h3FFF;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= rd_mem(int'(mem_addr));
    if (mem_wr_en) wmem[int'(mem_addr)] = mem_wdata;
  end

  // Reference model: 0 idle, 1 second word, 2 third word, 3 read, 4 write.
  int m_st = 0, m_op = 0, m_soff = 0, m_doff = 0, m_dst = 0;
  bit m_abort = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_abort = 0;
    end else begin
      bit acc;
      acc = word_valid && (m_st <= 2);
      m_abort = 0;
      case (m_st)
        0: if (acc) begin
          if (word_data[15:7] == 9'b111010110) begin m_op = 0; m_soff = int'(word_data[6:0]); m_st = 1; end
          else if (word_data[15:7] == 9'b111010111) begin m_op = 1; m_soff = int'(word_data[6:0]); m_st = 1; end
          else if (word_data == 16'h0062) begin m_op = 2; m_st = 1; end
        end
        1: if (acc) begin
          if (word_data[15:12] != 4'hF) begin m_abort = 1; m_st = 0; end
          else if (m_op == 0) begin m_dst = int'(word_data[11:0]); m_st = 3; end
          else if (m_op == 1) begin m_doff = int'(word_data[6:0]); m_st = 3; end
          else begin m_soff = int'(word_data[8:2]); m_dst = int'(word_data[1:0]) * 4096; m_st = 2; end
        end
        2: if (acc) begin
          if (word_data[15:12] != 4'hF) begin m_abort = 1; m_st = 0; end
          else begin m_dst = m_dst + int'(word_data[11:0]); m_st = 3; end
        end
        3: m_st = 4;
        default: m_st = 0;
      endcase
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare every cycle away from the clock edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int fp, src, dst;
      bit e_rdy, e_rd, e_wr, e_done, e_err;
      fp  = int'(frame_ptr);
      src = (fp + m_soff) % 16384;
      dst = (m_op == 1) ? (fp + m_doff) % 16384 : m_dst;
      e_rdy  = (m_st <= 2);
      e_rd   = (m_st == 3);
      e_done = (m_st == 4);
      e_wr   = e_done && !is_prot(dst) && !(m_op == 1 && is_ind(dst));
      e_err  = (e_done && is_prot(dst)) || m_abort;
      check(word_ready == e_rdy, "R10", "word_ready", int'(word_ready), int'(e_rdy));
      check(mem_rd_en == e_rd, "R11", "mem_rd_en", int'(mem_rd_en), int'(e_rd));
      check(mem_wr_en == e_wr, cur_req, "mem_wr_en", int'(mem_wr_en), int'(e_wr));
      check(done == e_done, "R11", "done", int'(done), int'(e_done));
      check(err == e_err, cur_req, "err", int'(err), int'(e_err));
      if (e_rd) check(int'(mem_addr) == src, "R5", "src addr", int'(mem_addr), src);
      if (e_wr) begin
        int ed;
        ed = is_ind(src) ? 0 : int'(rd_mem(src));
        check(int'(mem_addr) == dst, cur_req, "dst addr", int'(mem_addr), dst);
        check(int'(mem_wdata) == ed, is_ind(src) ? "R6" : cur_req, "wdata", int'(mem_wdata), ed);
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic send(logic [15:0] w);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = w;
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wmem['h85]   = 8'h33;
    wmem['h2085] = 8'h33;
    gap(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(word_ready && !mem_rd_en && !mem_wr_en && !done && !err, "R1", "reset state",
          {27'd0, word_ready, mem_rd_en, mem_wr_en, done, err}, 16);

    cur_req = "R2"; frame_ptr = 14'h0080;
    send(16'hEB05); send(16'hF100); gap(3);
    check(rd_mem('h100) == 8'h33, "R2", "mem[100]", int'(rd_mem('h100)), 'h33);

    cur_req = "R3";
    send(16'hEB85); gap(4); send(16'hFA86); gap(3);
    check(rd_mem('h86) == 8'h33, "R3", "mem[86]", int'(rd_mem('h86)), 'h33);

    cur_req = "R4"; frame_ptr = 14'h2080;
    send(16'h0062); gap(2); send(16'hFE16); send(16'hF000); gap(3);
    check(rd_mem('h2000) == 8'h33, "R4", "mem[2000]", int'(rd_mem('h2000)), 'h33);

    cur_req = "R5"; frame_ptr = 14'h3FF0;
    send(16'hEB7F); send(16'hF200); gap(3);
    check(rd_mem('h200) == 8'((('h6F) * 13 + 7) & 255), "R5", "mem[200]",
          int'(rd_mem('h200)), (('h6F) * 13 + 7) & 255);

    cur_req = "R6"; frame_ptr = 14'h3FE0;
    send(16'hEB0F); send(16'hF201); gap(3);
    check(rd_mem('h201) == 8'h00, "R6", "mem[201]", int'(rd_mem('h201)), 0);

    cur_req = "R7";
    send(16'hEB80); send(16'hF007); gap(3);
    check(!wmem.exists('h3FE7), "R7", "indirect dst written", int'(wmem.exists('h3FE7)), 0);

    cur_req = "R8";
    send(16'h0062); send(16'hF007); send(16'hFFF9); gap(3);
    check(!wmem.exists('h3FF9), "R8", "protected 3FF9 written", int'(wmem.exists('h3FF9)), 0);
    frame_ptr = 14'h3FF0;
    send(16'hEB81); send(16'hF00F); gap(3);
    check(!wmem.exists('h3FFF), "R8", "protected 3FFF written", int'(wmem.exists('h3FFF)), 0);

    cur_req = "R9"; frame_ptr = 14'h0080;
    send(16'hEB05); send(16'hE300); gap(2);
    check(!wmem.exists('h300), "R9", "aborted write", int'(wmem.exists('h300)), 0);
    send(16'h0062); send(16'hF014); send(16'h7301); gap(2);
    check(!wmem.exists('h301), "R9", "aborted long write", int'(wmem.exists('h301)), 0);
    send(16'hEB05); send(16'hF302); gap(3);
    check(rd_mem('h302) == 8'h33, "R9", "move after abort", int'(rd_mem('h302)), 'h33);

    cur_req = "R12";
    send(16'h1234); send(16'hF303); gap(3);
    check(!wmem.exists('h303), "R12", "stray word effect", int'(wmem.exists('h303)), 0);

    cur_req = "R10";
    send(16'hEB85); send(16'hF010); send(16'hEB05); send(16'hF304); gap(4);
    check(rd_mem('h90) == 8'h33 && rd_mem('h304) == 8'h33, "R10", "back-to-back moves",
          int'(rd_mem('h304)), 'h33);

    finish_run();
  end
endmodule